// File: doc/BRIEF.md
# Tensor Tile Copy Address Engine

This block turns one tile-copy command into a stream of per-element beats. A descriptor supplies the base byte address of a two-dimensional tensor in global memory, the tensor's width and height in elements, the row pitch in bytes and the element size in bytes. A start command supplies the tile origin (column, row) and the tile extent. After the start the engine runs on its own. It visits every tile element in row-major order and issues one beat per cycle whenever the downstream side is ready.

Each beat carries three things: a global read address, a shared-memory destination index and a valid-read flag. When an element lies inside the tensor, the beat asks for a read at base + row*pitch + col*elem_size. When an element lies past the tensor's right or bottom edge, the beat carries the flag cleared. It then stands for a zero write to that shared-memory slot, with no global read. A one-cycle done pulse marks the end of the copy. Moving the data itself is left to the surrounding datapath.

Top module: `tile_addr_engine`

## Requirements
- R1: Out of reset, beat_valid_o, busy_o and done_o are all 0.
- R2: Tile elements are emitted row-major: the tile column advances first, and after the last column it returns to 0 while the tile row advances.
- R3: For an in-bounds element the read address is base + (origin_row+r)*pitch_bytes + (origin_col+c)*elem_bytes, with the pitch counted in bytes.
- R4: The shared-memory index of element (r,c) is r*tile_w + c.
- R5: An element whose tensor column is >= tensor width or whose tensor row is >= tensor height is emitted with in_bounds_o=0 and read address 0. The downstream side writes zero for it and makes no read.
- R6: While beat_valid_o=1 and beat_ready_i=0, the beat's outputs hold stable and the walk does not advance.
- R7: A start arriving while busy_o=1 is ignored. The running walk and its beat count are unchanged.
- R8: done_o pulses for exactly one cycle, in the cycle after the last beat is accepted. busy_o falls in that same cycle.
- R9: A tile of tile_w*tile_h elements yields exactly that many accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| desc_base_i | input | ADDR_W | Tensor base byte address |
| desc_width_i | input | DIM_W | Tensor width in elements |
| desc_height_i | input | DIM_W | Tensor height in elements |
| desc_pitch_i | input | ADDR_W | Row pitch in bytes |
| desc_elem_bytes_i | input | ESZ_W | Element size in bytes |
| start_i | input | 1 | Start command, single cycle |
| tile_col_i | input | DIM_W | Tile origin column |
| tile_row_i | input | DIM_W | Tile origin row |
| tile_w_i | input | TDIM_W | Tile width in elements, 1 or more |
| tile_h_i | input | TDIM_W | Tile height in elements, 1 or more |
| beat_valid_o | output | 1 | Beat available |
| beat_ready_i | input | 1 | Downstream accepts the beat |
| rd_addr_o | output | ADDR_W | Global read byte address |
| smem_idx_o | output | SIDX_W | Shared-memory element index |
| in_bounds_o | output | 1 | 1 means read; 0 means zero-fill |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Copy finished pulse |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 16-bit tensor dimensions and 8-bit tile dimensions. With these, tiles that straddle the right edge, the bottom edge and the corner can all be reached. So can a pitch that is not a multiple of width*elem_size. Several element sizes are driven, and downstream backpressure is applied in a fixed pattern. A start command is issued in the middle of a copy to show that it has no effect.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  typedef struct packed {
    logic [31:0] base;
    logic [15:0] width;
    logic [15:0] height;
    logic [31:0] pitch;
    logic [3:0]  esz;
  } tdesc_t;
endpackage

// File: rtl/tile_walker.sv
module tile_walker #(
  parameter int TDIM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TDIM_W-1:0] tw_i,
  input  logic [TDIM_W-1:0] th_i,
  input  logic              adv_i,
  output logic [TDIM_W-1:0] col_o,
  output logic [TDIM_W-1:0] row_o,
  output logic              last_o
);
  logic [TDIM_W-1:0] tw_q, th_q;
  logic col_end;
  assign col_end = (col_o == tw_q - 1'b1);
  assign last_o  = col_end && (row_o == th_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o <= '0; row_o <= '0; tw_q <= '0; th_q <= '0;
    end else if (load_i) begin
      col_o <= '0; row_o <= '0; tw_q <= tw_i; th_q <= th_i;
    end else if (adv_i) begin
      if (col_end) begin
        col_o <= '0;
        row_o <= row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  // column wraps only together with a row step
  AST_ROW_MAJOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && col_end) |=> (col_o == '0)); // R2
endmodule

// File: rtl/tile_addr_calc.sv
module tile_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int TDIM_W = 8,
  parameter int ESZ_W  = 4,
  localparam int SIDX_W = 2*TDIM_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [ADDR_W-1:0] pitch_i,
  input  logic [ESZ_W-1:0]  esz_i,
  input  logic [DIM_W-1:0]  org_col_i,
  input  logic [DIM_W-1:0]  org_row_i,
  input  logic [TDIM_W-1:0] tw_i,
  input  logic [TDIM_W-1:0] col_i,
  input  logic [TDIM_W-1:0] row_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIDX_W-1:0] sidx_o,
  output logic              inb_o
);
  logic [DIM_W:0] gcol, grow;
  logic [ADDR_W-1:0] raw;
  assign gcol  = {1'b0, org_col_i} + (DIM_W+1)'(col_i);
  assign grow  = {1'b0, org_row_i} + (DIM_W+1)'(row_i);
  assign inb_o = (gcol < {1'b0, width_i}) && (grow < {1'b0, height_i});
  assign raw   = base_i + ADDR_W'(grow) * pitch_i + ADDR_W'(gcol) * ADDR_W'(esz_i);
  assign addr_o = inb_o ? raw : '0;
  assign sidx_o = SIDX_W'(row_i) * SIDX_W'(tw_i) + SIDX_W'(col_i);
endmodule

// File: rtl/tile_addr_engine.sv
module tile_addr_engine
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16,
  parameter int TDIM_W = 8,
  parameter int ESZ_W  = 4,
  localparam int SIDX_W = 2*TDIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] desc_base_i,
  input  logic [DIM_W-1:0]  desc_width_i,
  input  logic [DIM_W-1:0]  desc_height_i,
  input  logic [ADDR_W-1:0] desc_pitch_i,
  input  logic [ESZ_W-1:0]  desc_elem_bytes_i,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  tile_col_i,
  input  logic [DIM_W-1:0]  tile_row_i,
  input  logic [TDIM_W-1:0] tile_w_i,
  input  logic [TDIM_W-1:0] tile_h_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [SIDX_W-1:0] smem_idx_o,
  output logic              in_bounds_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] base_q, pitch_q;
  logic [DIM_W-1:0]  wid_q, hgt_q, ocol_q, orow_q;
  logic [ESZ_W-1:0]  esz_q;
  logic [TDIM_W-1:0] tw_q, col, row;
  logic busy_q, done_q, last, load, fire;

  assign load = start_i && !busy_q;
  assign fire = busy_q && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; pitch_q <= '0; wid_q <= '0; hgt_q <= '0;
      ocol_q <= '0; orow_q <= '0; esz_q <= '0; tw_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        base_q <= desc_base_i; pitch_q <= desc_pitch_i;
        wid_q <= desc_width_i; hgt_q <= desc_height_i;
        esz_q <= desc_elem_bytes_i; ocol_q <= tile_col_i;
        orow_q <= tile_row_i; tw_q <= tile_w_i;
        busy_q <= 1'b1;
      end else if (fire && last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  tile_walker #(.TDIM_W(TDIM_W)) u_walk (
    .clk_i, .rst_ni, .load_i(load), .tw_i(tile_w_i), .th_i(tile_h_i),
    .adv_i(fire), .col_o(col), .row_o(row), .last_o(last)
  );

  tile_addr_calc #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .TDIM_W(TDIM_W), .ESZ_W(ESZ_W)) u_calc (
    .base_i(base_q), .width_i(wid_q), .height_i(hgt_q), .pitch_i(pitch_q),
    .esz_i(esz_q), .org_col_i(ocol_q), .org_row_i(orow_q), .tw_i(tw_q),
    .col_i(col), .row_i(row), .addr_o(rd_addr_o), .sidx_o(smem_idx_o),
    .inb_o(in_bounds_o)
  );

  assign beat_valid_o = busy_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(rd_addr_o) && $stable(smem_idx_o) && $stable(in_bounds_o))); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !beat_ready_i) |=> $stable(smem_idx_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !in_bounds_o) |-> (rd_addr_o == '0)); // R5
endmodule

// File: tb/tile_addr_engine_tb.sv
module tile_addr_engine_tb;
  logic clk_i = 0, rst_ni = 0;
  logic [31:0] desc_base_i = 0, desc_pitch_i = 0;
  logic [15:0] desc_width_i = 0, desc_height_i = 0, tile_col_i = 0, tile_row_i = 0;
  logic [3:0]  desc_elem_bytes_i = 0;
  logic start_i = 0, beat_ready_i = 0;
  logic [7:0] tile_w_i = 0, tile_h_i = 0;
  logic beat_valid_o, in_bounds_o, busy_o, done_o;
  logic [31:0] rd_addr_o;
  logic [15:0] smem_idx_o;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  tile_addr_engine u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // full tile walk; stall_mask stalls beats where (n % 3 == 1), mid_start injects a start
  task automatic run_tile(input int bx, input int w, input int h, input int pitch, input int esz,
                          input int oc, input int orow, input int tw, input int th,
                          input bit stall, input bit mid_start);
    int n = 0;
    desc_base_i = bx; desc_width_i = w; desc_height_i = h; desc_pitch_i = pitch;
    desc_elem_bytes_i = esz; tile_col_i = oc; tile_row_i = orow; tile_w_i = tw; tile_h_i = th;
    @(negedge clk_i); start_i = 1; @(negedge clk_i); start_i = 0;
    for (int r = 0; r < th; r++) begin
      for (int c = 0; c < tw; c++) begin
        bit inb = (oc + c < w) && (orow + r < h);
        int ea = inb ? bx + (orow + r) * pitch + (oc + c) * esz : 0;
        if (stall && (n % 3 == 1)) begin
          beat_ready_i = 0;
          if (mid_start) begin
            start_i = 1; tile_col_i = 0; tile_row_i = 0; tile_w_i = 1; tile_h_i = 1;
          end
          @(negedge clk_i); start_i = 0;
          chk("R6", smem_idx_o, r * tw + c);
          chk("R7", busy_o, 1);
        end
        beat_ready_i = 1;
        chk("R9", beat_valid_o, 1);
        chk("R2/R4", smem_idx_o, r * tw + c);
        chk("R5", in_bounds_o, inb);
        chk("R3", rd_addr_o, ea);
        chk("R8", done_o, 0);
        @(negedge clk_i);
        n++;
      end
    end
    beat_ready_i = 0;
    chk("R8", done_o, 1);
    chk("R8", busy_o, 0);
    chk("R9", beat_valid_o, 0);
    @(negedge clk_i);
    chk("R8", done_o, 0);
  endtask

  task automatic t_reset();
    chk("R1", beat_valid_o, 0); chk("R1", busy_o, 0); chk("R1", done_o, 0);
  endtask

  initial begin
    #1000; $display("FAIL watchdog expired"); errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors); $finish;
  end

  initial begin
    #1; t_reset();
    repeat (2) @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); t_reset();
    run_tile(32'h1000, 16, 12, 100, 4, 2, 3, 4, 3, 0, 0);     // inside
    run_tile(32'h8000, 10, 8, 52, 2, 7, 1, 5, 2, 1, 0);       // right edge, stall
    run_tile(32'h200, 20, 5, 84, 8, 1, 3, 3, 4, 0, 0);        // bottom edge
    run_tile(32'h40, 6, 6, 30, 1, 4, 4, 4, 4, 1, 1);          // corner, mid start
    run_tile(32'h10, 4, 4, 16, 4, 0, 0, 1, 1, 0, 0);          // single element
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule